// File: doc/BRIEF.md
# Flag Pin GPIO Bank

This block manages a bank of general-purpose flag pins through a small register window. Software chooses each pin's direction, drives output levels and arms per-pin interrupts. Levels and mask bits never change through a plain overwrite. One address raises the bits written as 1, and a companion address lowers them. Bits written as 0 leave their flop untouched. This lets several agents change separate pins without a read-modify-write race.

Each input pin passes through a synchroniser. A rising edge on a pin that is configured as an input latches a pending flag for that pin. Pending flags gated by the mask bits are ORed into one interrupt line. Writing 1 to a bit of the flag-lower address drops that output level and also clears that pin's pending flag. For each pin the pads receive an output enable, which equals the direction bit, and an output value.

Top module: `flag_gpio_bank`

## Requirements
- R1: While reset is low and on the first cycle after it, `pinOe`, `pinOut`, `irq` and all mask bits are zero, and `rdData` is zero until the first read.
- R2: Register index 0 (byte offset 0x0) holds the direction bits and is written in full. A bit of 1 drives the matching `pinOe` bit high (output), and 0 makes the pin an input. `pinOe` changes only after such a write.
- R3: A write to index 2 (offset 0x8) sets every `pinOut` bit whose data bit is 1 and leaves the bits written 0 unchanged.
- R4: A write to index 1 (offset 0x4) clears every `pinOut` bit whose data bit is 1 and leaves the bits written 0 unchanged.
- R5: A write to index 4 (offset 0x10) sets the mask bits written as 1, and a write to index 3 (offset 0xC) clears them. A read of either index returns the current mask.
- R6: A read of index 1 or 2 returns, per bit, the driven output value for output pins and the synchronised pad level for input pins. A pad change applied before clock edge k is seen by a read issued on the cycle after edge k+1.
- R7: A 0-to-1 transition of a synchronised input latches that pin's pending flag, one edge after the synchronised level rises. Falling edges do nothing, and pins configured as outputs never latch.
- R8: Writing 1 to a bit of index 1 clears that pin's pending flag. If a new rising edge is detected in the same cycle, the flag stays set.
- R9: `irq` is high exactly when some pin has both its pending flag and its mask bit set. Clearing the mask hides a pending flag without discarding it.
- R10: `rdData` is registered. It loads on the clock edge where `rdEn` is high, using the state before that edge, and holds otherwise. Indices 5 to 7 read as zero and ignore writes. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | 5 | Byte address; bits [4:2] select the register |
| wrData | input | 16 | Write data, one bit per pin |
| rdData | output | 16 | Registered read data |
| pinIn | input | 16 | Pad input levels (asynchronous) |
| pinOe | output | 16 | Per-pin output enable |
| pinOut | output | 16 | Per-pin output value |
| irq | output | 1 | Combined masked interrupt |

## Verification
On every cycle, the bound properties check the following:
- each write to the direction, level and mask registers has its effect on the next cycle;
- `pinOe` does not move without a direction write;
- `rdData` holds when no read is issued;
- `irq` stays low whenever the mask is empty.

Only the bench scenarios can show the rest, against a cycle model:
- the synchroniser latency and edge-only latching;
- the collision between a flag-clear write and a newly arriving edge;
- the preservation of pending flags behind a cleared mask.

// File: rtl/flag_gpio_pkg.sv
package flag_gpio_pkg;

  // register indices (byte offset >> 2)
  localparam int IDX_DIR  = 0;
  localparam int IDX_FCLR = 1;
  localparam int IDX_FSET = 2;
  localparam int IDX_MCLR = 3;
  localparam int IDX_MSET = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_MASK = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   dirWr;
    logic   flagSet;
    logic   flagClr;
    logic   maskSet;
    logic   maskClr;
    logic   rdStb;
    rdSel_e rdSel;
  } ctrlStb_t;

endpackage

// File: rtl/flag_gpio_ctrl.sv
module flag_gpio_ctrl
  import flag_gpio_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStb_t          stb
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic hitDir, hitFclr, hitFset, hitMclr, hitMset;

  assign idx     = addr[ADDR_W-1:2];
  assign hitDir  = (idx == IDX_W'(IDX_DIR));
  assign hitFclr = (idx == IDX_W'(IDX_FCLR));
  assign hitFset = (idx == IDX_W'(IDX_FSET));
  assign hitMclr = (idx == IDX_W'(IDX_MCLR));
  assign hitMset = (idx == IDX_W'(IDX_MSET));

  always_comb begin
    stb         = '0;
    stb.dirWr   = wrEn & hitDir;
    stb.flagSet = wrEn & hitFset;
    stb.flagClr = wrEn & hitFclr;
    stb.maskSet = wrEn & hitMset;
    stb.maskClr = wrEn & hitMclr;
    stb.rdStb   = rdEn;
    if (hitDir)                stb.rdSel = SEL_DIR;
    else if (hitFclr | hitFset) stb.rdSel = SEL_FLAG;
    else if (hitMclr | hitMset) stb.rdSel = SEL_MASK;
    else                        stb.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/flag_gpio_pin.sv
module flag_gpio_pin
  import flag_gpio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  ctrlStb_t stb,
  input  logic     wrBit,
  input  logic     padIn,
  output logic     dirBit,
  output logic     outBit,
  output logic     maskBit,
  output logic     pendBit,
  output logic     senseBit
);

  logic [SYNC_STAGES-1:0] syncSh;
  logic                   prevBit;
  logic                   riseBit;
  logic                   syncBit;

  assign syncBit = syncSh[SYNC_STAGES-1];
  assign riseBit = syncBit & ~prevBit & ~dirBit;

  // pad synchroniser and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncSh  <= '0;
      prevBit <= 1'b0;
    end else begin
      syncSh  <= {syncSh[SYNC_STAGES-2:0], padIn};
      prevBit <= syncBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirBit <= 1'b0;
    else if (stb.dirWr) dirBit <= wrBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outBit <= 1'b0;
    else if (stb.flagSet && wrBit) outBit <= 1'b1;
    else if (stb.flagClr && wrBit) outBit <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskBit <= 1'b0;
    else if (stb.maskSet && wrBit) maskBit <= 1'b1;
    else if (stb.maskClr && wrBit) maskBit <= 1'b0;
  end

  // a fresh edge wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendBit <= 1'b0;
    else pendBit <= (pendBit & ~(stb.flagClr & wrBit)) | riseBit;
  end

  assign senseBit = dirBit ? outBit : syncBit;

endmodule

// File: rtl/flag_gpio_dp.sv
module flag_gpio_dp
  import flag_gpio_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStb_t            stb,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] maskBits,
  output logic [NUM_PINS-1:0] pendFlags,
  output logic                irq
);

  logic [NUM_PINS-1:0] senseBits;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    flag_gpio_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk     (clk),
      .rstN    (rstN),
      .stb     (stb),
      .wrBit   (wrData[p]),
      .padIn   (pinIn[p]),
      .dirBit  (pinOe[p]),
      .outBit  (pinOut[p]),
      .maskBit (maskBits[p]),
      .pendBit (pendFlags[p]),
      .senseBit(senseBits[p])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (stb.rdStb) begin
      case (stb.rdSel)
        SEL_DIR:  rdData <= pinOe;
        SEL_FLAG: rdData <= senseBits;
        SEL_MASK: rdData <= maskBits;
        default:  rdData <= '0;
      endcase
    end
  end

  assign irq = |(pendFlags & maskBits);

endmodule

// File: rtl/flag_gpio_bank.sv
module flag_gpio_bank
  import flag_gpio_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] pinOut,
  output logic                irq
);

  ctrlStb_t            stb;
  logic [NUM_PINS-1:0] maskBits;
  logic [NUM_PINS-1:0] pendFlags;

  flag_gpio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn),
    .rdEn(rdEn),
    .addr(addr),
    .stb (stb)
  );

  flag_gpio_dp #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .pinIn    (pinIn),
    .rdData   (rdData),
    .pinOe    (pinOe),
    .pinOut   (pinOut),
    .maskBits (maskBits),
    .pendFlags(pendFlags),
    .irq      (irq)
  );

endmodule

// File: rtl/flag_gpio_chk.sv
module flag_gpio_chk #(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic                rdEn,
  input logic [ADDR_W-1:0]   addr,
  input logic [NUM_PINS-1:0] wrData,
  input logic [NUM_PINS-1:0] rdData,
  input logic [NUM_PINS-1:0] pinOe,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] maskBits,
  input logic                irq
);

  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:2];

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinOe == '0 && pinOut == '0 && !irq && maskBits == '0)); // R1
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == IDX_W'(0)) |=> (pinOe == $past(wrData))); // R2
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && idx == IDX_W'(0)) |=> $stable(pinOe)); // R2
  AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == IDX_W'(2)) |=> ((pinOut & $past(wrData)) == $past(wrData))); // R3
  AST_LEVEL_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == IDX_W'(1)) |=> ((pinOut & $past(wrData)) == '0)); // R4
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == IDX_W'(4)) |=> ((maskBits & $past(wrData)) == $past(wrData))); // R5
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == IDX_W'(3)) |=> ((maskBits & $past(wrData)) == '0)); // R5
  AST_MASK_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == IDX_W'(3) && wrData == '1) |=> !irq); // R9
  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (maskBits == '0) |-> !irq); // R9
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R10

endmodule

bind flag_gpio_bank flag_gpio_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .rdEn    (rdEn),
  .addr    (addr),
  .wrData  (wrData),
  .rdData  (rdData),
  .pinOe   (pinOe),
  .pinOut  (pinOut),
  .maskBits(maskBits),
  .irq     (irq)
);

// File: tb/sim_flag_gpio_bank.sv
`timescale 1ns/1ps
module sim_flag_gpio_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [15:0] pinIn = '0;
  logic [15:0] pinOe;
  logic [15:0] pinOut;
  logic        irq;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 1'b0;
  string curReq = "R1";

  // reference state
  logic [15:0] mDir = '0, mOut = '0, mMask = '0, mPend = '0;
  logic [15:0] mS1 = '0, mS2 = '0, mPrev = '0, mRd = '0;

  always #2 clk = ~clk;

  flag_gpio_bank u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn),
    .pinOe(pinOe), .pinOut(pinOut), .irq(irq)
  );

  function automatic logic [15:0] readVal(input logic [2:0] idx);
    case (idx)
      3'd0:       return mDir;
      3'd1, 3'd2: return (mDir & mOut) | (~mDir & mS2);
      3'd3, 3'd4: return mMask;
      default:    return 16'h0;
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    logic [2:0]  idx;
    logic [15:0] rise;
    @(posedge clk);
    idx = addr[4:2];
    if (!rstN) begin
      mDir = '0; mOut = '0; mMask = '0; mPend = '0;
      mS1 = '0; mS2 = '0; mPrev = '0; mRd = '0;
    end else begin
      if (rdEn) mRd = readVal(idx);
      rise = mS2 & ~mPrev & ~mDir;
      if (wrEn && idx == 3'd1) mPend = mPend & ~wrData;
      mPend = mPend | rise;
      if (wrEn) begin
        case (idx)
          3'd0: mDir  = wrData;
          3'd1: mOut  = mOut & ~wrData;
          3'd2: mOut  = mOut | wrData;
          3'd3: mMask = mMask & ~wrData;
          3'd4: mMask = mMask | wrData;
          default: ;
        endcase
      end
      mPrev = mS2; mS2 = mS1; mS1 = pinIn;
    end
    @(negedge clk);
    check("R2", {curReq, " pinOe"},  pinOe,  mDir);
    check("R3", {curReq, " pinOut"}, pinOut, mOut);
    check("R9", {curReq, " irq"},    {15'h0, irq}, {15'h0, |(mPend & mMask)});
    check("R6", {curReq, " rdData"}, rdData, mRd);
  endtask

  task automatic wr(input logic [2:0] idx, input logic [15:0] d);
    wrEn = 1'b1; addr = {idx, 2'b00}; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx);
    rdEn = 1'b1; addr = {idx, 2'b00};
    tick();
    rdEn = 1'b0;
  endtask

  initial begin
    #800000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    curReq = "R1";
    repeat (3) tick();
    check("R1", "reset pinOe", pinOe, 16'h0);
    check("R1", "reset pinOut", pinOut, 16'h0);
    check("R1", "reset irq", {15'h0, irq}, 16'h0);
    rstN = 1'b1;
    tick();
    rd(3'd4);
    check("R1", "mask after reset", rdData, 16'h0);

    curReq = "R2";
    wr(3'd0, 16'hFF00);
    rd(3'd0);
    check("R2", "direction readback", rdData, 16'hFF00);

    curReq = "R3";
    wr(3'd2, 16'h0F0F);
    wr(3'd2, 16'h00F0);
    check("R3", "level set", pinOut, 16'h0FFF);
    curReq = "R4";
    wr(3'd1, 16'h0003);
    check("R4", "level clear", pinOut, 16'h0FFC);

    curReq = "R6";
    pinIn = 16'h00A5;
    tick(); tick();
    rd(3'd2);
    check("R6", "sensed mix", rdData, 16'h0FA5);
    rd(3'd1);

    curReq = "R10";
    wr(3'd5, 16'hFFFF);
    wr(3'd7, 16'hFFFF);
    rd(3'd6);
    check("R10", "unmapped read", rdData, 16'h0);
    rd(3'd0);
    check("R10", "dir untouched", rdData, 16'hFF00);

    curReq = "R5";
    wr(3'd4, 16'h00FF);
    wr(3'd3, 16'h000F);
    rd(3'd3);
    check("R5", "mask readback", rdData, 16'h00F0);
    wr(3'd1, 16'hFFFF);

    curReq = "R7";
    pinIn = 16'h0000;
    tick(); tick(); tick();
    wr(3'd1, 16'hFFFF);
    pinIn = 16'h8010;  // bit 15 is an output: no latch
    tick(); tick(); tick();
    check("R7", "rise on masked input", {15'h0, irq}, 16'h1);
    pinIn = 16'h0000;
    tick(); tick(); tick();
    wr(3'd1, 16'h0010);
    check("R7", "after clear", {15'h0, irq}, 16'h0);

    curReq = "R8";
    pinIn = 16'h0020;
    tick(); tick();
    wr(3'd1, 16'h0020);  // clear meets new edge
    check("R8", "edge wins over clear", {15'h0, irq}, 16'h1);
    wr(3'd1, 16'h0020);
    check("R8", "clear takes", {15'h0, irq}, 16'h0);

    curReq = "R9";
    pinIn = 16'h0060;
    tick(); tick(); tick();
    wr(3'd3, 16'hFFFF);
    check("R9", "masked off", {15'h0, irq}, 16'h0);
    wr(3'd4, 16'h0040);
    check("R9", "pending kept", {15'h0, irq}, 16'h1);

    curReq = "random";
    for (int i = 0; i < 4000; i++) begin
      wrEn   = ($urandom % 3) == 0;
      rdEn   = ($urandom % 2) == 0;
      addr   = 5'($urandom);
      wrData = 16'($urandom);
      if (($urandom % 4) == 0) pinIn = pinIn ^ (16'($urandom) & 16'($urandom));
      tick();
    end
    wrEn = 1'b0; rdEn = 1'b0;
    tick();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule